// File: doc/BRIEF.md
# Legacy I/O Trap Decoder

This block watches the I/O cycles of a bridge and flags any access that lands inside one of ten fixed-function legacy device windows. These windows cover two disk channels, two serial ports, a parallel port, a floppy controller, an audio codec, a MIDI port, a keyboard controller and an FM synthesizer. Each window is switched on by a bit in one of two enable bytes. Where a device can sit at more than one address, a field in one of three select bytes picks its base from a fixed table.

Each cycle, the block compares the 16-bit I/O address against every enabled window while the valid strobe is high. It registers the per-window hit vector, and a combined trap pulse that is high whenever any window hit. A downstream management unit consumes these outputs. The block itself takes no action on a trap.

Top module: `io_trap_decoder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `win_hit` and `trap_pulse` are 0 after that edge, whatever the other inputs are.
- R2: `win_hit[i]` is 1 in the cycle after an edge where `io_valid` was 1, window i was enabled and the address lay in one of its ranges; otherwise it is 0. Bit order: 0 primary disk, 1 secondary disk, 2 serial A, 3 serial B, 4 parallel, 5 floppy, 6 audio codec, 7 MIDI, 8 keyboard, 9 FM.
- R3: The serial A base comes from `sel_serial[2:0]` and the serial B base from `sel_serial[6:4]`. Codes 0..7 map to 0x3F8, 0x2F8, 0x220, 0x228, 0x238, 0x2E8, 0x338 and 0x3E8. Each window is 8 bytes and is enabled by `trap_en_a[4]`.
- R4: The parallel base comes from `sel_misc[1:0]`: 0 gives 0x378, 1 gives 0x278 and 2 gives 0x3BC. Each is 8 bytes. Code 3 matches no address. The window is enabled by `trap_en_a[4]`.
- R5: The floppy window is 0x3F0..0x3F7 when `sel_misc[4]` is 1 and 0x370..0x377 when it is 0. It is enabled by `trap_en_a[4]`.
- R6: The primary disk window covers 0x1F0..0x1F7 and 0x3F6 and is enabled by `trap_en_a[0]`. The secondary disk window covers 0x170..0x177 and 0x376 and is enabled by `trap_en_a[1]`.
- R7: The audio codec base comes from `sel_audio[5:4]`: 0x530, 0x604, 0xE80 or 0xF40, each 8 bytes. It is enabled by `trap_en_b[2]`.
- R8: The MIDI window is 0x300..0x301 when `sel_audio[3]` is 1 and 0x330..0x331 when it is 0. It is enabled by `trap_en_b[3]`.
- R9: The keyboard window covers 0x60..0x63 and is enabled by `trap_en_b[4]`. The FM window covers 0x388..0x38B and is enabled by `trap_en_b[5]`.
- R10: An address that lies in several enabled windows sets every matching bit of `win_hit` in the same cycle.
- R11: `trap_pulse` equals the OR of `win_hit` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O cycle address |
| io_valid | input | 1 | High when `io_addr` carries a live I/O cycle |
| trap_en_a | input | 8 | Enable bits for the disk, serial, parallel and floppy windows |
| trap_en_b | input | 8 | Enable bits for the codec, MIDI, keyboard and FM windows |
| sel_serial | input | 8 | Serial A and serial B base select codes |
| sel_misc | input | 8 | Parallel base code and floppy base bit |
| sel_audio | input | 8 | Codec base code and MIDI base bit |
| win_hit | output | 10 | Registered per-window hit vector |
| trap_pulse | output | 1 | Registered OR of all window hits |

## Verification
The assertions assume that the enable and select bytes are stable, 2-state values at each sampled edge, and that the address is only meaningful while `io_valid` is high. They judge each edge purely from the inputs sampled at that edge.

The stimulus respects this by changing every input only on falling edges. It then sweeps every select code, including the unused parallel code. Addresses are drawn around each window edge, one byte either side, with enables and the valid strobe toggled at random. Directed overlaps also put two windows on the same address.

// File: rtl/io_trap_pkg.sv
// io_trap_pkg: shared widths, window indices, range type and the fixed
// base-address tables of the legacy trap decoder.
// Assumes: all I/O addresses fit in ADDR_W bits; window lengths are <= 15.
package io_trap_pkg;
    localparam int ADDR_W  = 16;
    localparam int NUM_WIN = 10;
    localparam int LEN_W   = 4;

    localparam int W_PDISK  = 0;
    localparam int W_SDISK  = 1;
    localparam int W_SERA   = 2;
    localparam int W_SERB   = 3;
    localparam int W_PAR    = 4;
    localparam int W_FLOPPY = 5;
    localparam int W_CODEC  = 6;
    localparam int W_MIDI   = 7;
    localparam int W_KBD    = 8;
    localparam int W_FM     = 9;

    // One address range: base, byte count, and whether it exists at all.
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LEN_W-1:0]  len;
        logic              live;
    } io_range_t;

    function automatic io_range_t mk_range(input logic [ADDR_W-1:0] b,
                                           input logic [LEN_W-1:0] l);
        io_range_t r;
        r.base = b;
        r.len  = l;
        r.live = 1'b1;
        return r;
    endfunction

    localparam io_range_t NO_RANGE = '0;

    // Serial port base table, shared by both serial windows.
    function automatic logic [ADDR_W-1:0] serial_base(input logic [2:0] code);
        logic [ADDR_W-1:0] b;
        case (code)
            3'd0:    b = 16'h03F8;
            3'd1:    b = 16'h02F8;
            3'd2:    b = 16'h0220;
            3'd3:    b = 16'h0228;
            3'd4:    b = 16'h0238;
            3'd5:    b = 16'h02E8;
            3'd6:    b = 16'h0338;
            default: b = 16'h03E8;
        endcase
        return b;
    endfunction

    // Parallel port range; code 3 has no defined base and yields no range.
    function automatic io_range_t parallel_range(input logic [1:0] code);
        io_range_t r;
        case (code)
            2'd0:    r = mk_range(16'h0378, 4'd8);
            2'd1:    r = mk_range(16'h0278, 4'd8);
            2'd2:    r = mk_range(16'h03BC, 4'd8);
            default: r = NO_RANGE;
        endcase
        return r;
    endfunction

    // Audio codec base table.
    function automatic logic [ADDR_W-1:0] codec_base(input logic [1:0] code);
        logic [ADDR_W-1:0] b;
        case (code)
            2'd0:    b = 16'h0530;
            2'd1:    b = 16'h0604;
            2'd2:    b = 16'h0E80;
            default: b = 16'h0F40;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/io_trap_window_map.sv
// io_trap_window_map: turns the enable and select bytes into one main and
// one auxiliary address range plus an enable bit per window.
// Assumes: configuration bytes are quasi-static; purely combinational.
module io_trap_window_map
    import io_trap_pkg::*;
(
    input  logic [7:0]                  trap_en_a,
    input  logic [7:0]                  trap_en_b,
    input  logic [7:0]                  sel_serial,
    input  logic [7:0]                  sel_misc,
    input  logic [7:0]                  sel_audio,
    output io_range_t [NUM_WIN-1:0]     rng_main,
    output io_range_t [NUM_WIN-1:0]     rng_aux,
    output logic [NUM_WIN-1:0]          win_en
);
    // Per-window enable bits; serial, parallel and floppy share one bit.
    always_comb begin
        win_en           = '0;
        win_en[W_PDISK]  = trap_en_a[0];
        win_en[W_SDISK]  = trap_en_a[1];
        win_en[W_SERA]   = trap_en_a[4];
        win_en[W_SERB]   = trap_en_a[4];
        win_en[W_PAR]    = trap_en_a[4];
        win_en[W_FLOPPY] = trap_en_a[4];
        win_en[W_CODEC]  = trap_en_b[2];
        win_en[W_MIDI]   = trap_en_b[3];
        win_en[W_KBD]    = trap_en_b[4];
        win_en[W_FM]     = trap_en_b[5];
    end

    // Main range of each window, resolved from the select fields.
    always_comb begin
        rng_main           = '0;
        rng_main[W_PDISK]  = mk_range(16'h01F0, 4'd8);
        rng_main[W_SDISK]  = mk_range(16'h0170, 4'd8);
        rng_main[W_SERA]   = mk_range(serial_base(sel_serial[2:0]), 4'd8);
        rng_main[W_SERB]   = mk_range(serial_base(sel_serial[6:4]), 4'd8);
        rng_main[W_PAR]    = parallel_range(sel_misc[1:0]);
        rng_main[W_FLOPPY] = mk_range(sel_misc[4] ? 16'h03F0 : 16'h0370, 4'd8);
        rng_main[W_CODEC]  = mk_range(codec_base(sel_audio[5:4]), 4'd8);
        rng_main[W_MIDI]   = mk_range(sel_audio[3] ? 16'h0300 : 16'h0330, 4'd2);
        rng_main[W_KBD]    = mk_range(16'h0060, 4'd4);
        rng_main[W_FM]     = mk_range(16'h0388, 4'd4);
    end

    // Auxiliary ranges: only the disk windows own a second (control) port.
    always_comb begin
        rng_aux          = '0;
        rng_aux[W_PDISK] = mk_range(16'h03F6, 4'd1);
        rng_aux[W_SDISK] = mk_range(16'h0376, 4'd1);
    end
endmodule

// File: rtl/io_trap_window_cmp.sv
// io_trap_window_cmp: range comparator for one window. Hits when the cycle
// is valid, the window is enabled and the address is in either live range.
// Assumes: base + len does not exceed 2**ADDR_W (checked with a wider sum).
module io_trap_window_cmp
    import io_trap_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    input  logic          valid,
    input  logic          en,
    input  io_range_t     rng_main,
    input  io_range_t     rng_aux,
    output logic          hit
);
    localparam int CW = AW + 1;

    logic in_main, in_aux;

    // Half-open interval test [base, base+len) on a carry-extended sum.
    function automatic logic in_range(input logic [AW-1:0] a, input io_range_t r);
        logic [CW-1:0] lo, hi, av;
        lo = CW'(r.base);
        hi = CW'(r.base) + CW'(r.len);
        av = CW'(a);
        return r.live && (av >= lo) && (av < hi);
    endfunction

    // Compare against both ranges and gate with strobe and enable.
    always_comb begin
        in_main = in_range(addr, rng_main);
        in_aux  = in_range(addr, rng_aux);
        hit     = valid && en && (in_main || in_aux);
    end
endmodule

// File: rtl/io_trap_decoder.sv
// io_trap_decoder: legacy I/O trap decoder top. Maps configuration bytes to
// windows, compares every window in parallel and registers the hit vector
// and the combined trap pulse one cycle after the I/O cycle.
// Assumes: inputs synchronous to clk; synchronous active-low reset.
module io_trap_decoder
    import io_trap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        io_addr,
    input  logic               io_valid,
    input  logic [7:0]         trap_en_a,
    input  logic [7:0]         trap_en_b,
    input  logic [7:0]         sel_serial,
    input  logic [7:0]         sel_misc,
    input  logic [7:0]         sel_audio,
    output logic [9:0]         win_hit,
    output logic               trap_pulse
);
    io_range_t [NUM_WIN-1:0] rng_main;
    io_range_t [NUM_WIN-1:0] rng_aux;
    logic [NUM_WIN-1:0]      win_en;
    logic [NUM_WIN-1:0]      hit_d;

    io_trap_window_map i_map (
        .trap_en_a  (trap_en_a),
        .trap_en_b  (trap_en_b),
        .sel_serial (sel_serial),
        .sel_misc   (sel_misc),
        .sel_audio  (sel_audio),
        .rng_main   (rng_main),
        .rng_aux    (rng_aux),
        .win_en     (win_en)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        io_trap_window_cmp #(.AW(ADDR_W)) i_cmp (
            .addr     (io_addr),
            .valid    (io_valid),
            .en       (win_en[w]),
            .rng_main (rng_main[w]),
            .rng_aux  (rng_aux[w]),
            .hit      (hit_d[w])
        );
    end

    // Register the hit vector and its OR; cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_hit    <= '0;
            trap_pulse <= 1'b0;
        end else begin
            win_hit    <= hit_d;
            trap_pulse <= |hit_d;
        end
    end

    // R2
    no_valid_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_valid |=> (win_hit == '0));

    // R6
    pdisk_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_en_a[0] |=> !win_hit[W_PDISK]);

    // R3
    legacy_group_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_en_a[4] |=> (win_hit[W_FLOPPY:W_SERA] == '0));

    // R9
    kbd_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && trap_en_b[4] && io_addr >= 16'h0060 && io_addr <= 16'h0063)
        |=> win_hit[W_KBD]);

    // R11
    trap_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> $past(io_valid));

    // R4
    par_code3_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_misc[1:0] == 2'd3) |=> !win_hit[W_PAR]);
endmodule

// File: tb/test_io_trap_decoder.sv
module test_io_trap_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_valid = 1'b0;
    logic [7:0]  trap_en_a = '0, trap_en_b = '0;
    logic [7:0]  sel_serial = '0, sel_misc = '0, sel_audio = '0;
    logic [9:0]  win_hit;
    logic        trap_pulse;

    int checks = 0;
    int errors = 0;
    logic [9:0] exp_q = '0;
    bit pend = 0;
    bit done = 0;

    always #4 clk = ~clk;

    io_trap_decoder i_io_trap_decoder (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_valid(io_valid),
        .trap_en_a(trap_en_a), .trap_en_b(trap_en_b), .sel_serial(sel_serial),
        .sel_misc(sel_misc), .sel_audio(sel_audio),
        .win_hit(win_hit), .trap_pulse(trap_pulse)
    );

    int ser_tab[8] = '{'h3F8, 'h2F8, 'h220, 'h228, 'h238, 'h2E8, 'h338, 'h3E8};
    int cod_tab[4] = '{'h530, 'h604, 'hE80, 'hF40};
    int par_tab[3] = '{'h378, 'h278, 'h3BC};

    function automatic bit inr(int a, int b, int n);
        return (a >= b) && (a < b + n);
    endfunction

    // Behavioural reference of the requirements.
    function automatic logic [9:0] model(int a, bit v, logic [7:0] ea, logic [7:0] eb,
                                         logic [7:0] ss, logic [7:0] sm, logic [7:0] sa);
        logic [9:0] h = '0;
        if (!v) return '0;
        h[0] = ea[0] && (inr(a, 'h1F0, 8) || inr(a, 'h3F6, 1));   // R6
        h[1] = ea[1] && (inr(a, 'h170, 8) || inr(a, 'h376, 1));   // R6
        h[2] = ea[4] && inr(a, ser_tab[ss[2:0]], 8);              // R3
        h[3] = ea[4] && inr(a, ser_tab[ss[6:4]], 8);              // R3
        h[4] = ea[4] && (sm[1:0] != 3) && inr(a, par_tab[sm[1:0] % 3], 8); // R4
        h[5] = ea[4] && inr(a, sm[4] ? 'h3F0 : 'h370, 8);         // R5
        h[6] = eb[2] && inr(a, cod_tab[sa[5:4]], 8);              // R7
        h[7] = eb[3] && inr(a, sa[3] ? 'h300 : 'h330, 2);         // R8
        h[8] = eb[4] && inr(a, 'h60, 4);                          // R9
        h[9] = eb[5] && inr(a, 'h388, 4);                         // R9
        return h;
    endfunction

    function automatic string req_of(int b);
        case (b)
            0, 1: return "R6";
            2, 3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R7";
            7: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Compare outputs against the pending expectation, away from the edge.
    task automatic compare(string tag);
        string rq;
        checks++;
        if (win_hit !== exp_q) begin
            rq = tag;
            if (rq == "") begin
                rq = "R2";
                for (int b = 0; b < 10; b++)
                    if (win_hit[b] !== exp_q[b] && exp_q != 0 && win_hit != 0) rq = req_of(b);
                if ($countones(exp_q) > 1) rq = "R10";
            end
            errors++;
            $display("FAIL %s win_hit actual=%b expected=%b", rq, win_hit, exp_q);
        end
        checks++;
        if (trap_pulse !== (|exp_q)) begin
            errors++;
            $display("FAIL R11 trap_pulse actual=%b expected=%b", trap_pulse, |exp_q);
        end
    endtask

    task automatic step(int a, bit v, logic [7:0] ea, logic [7:0] eb,
                        logic [7:0] ss, logic [7:0] sm, logic [7:0] sa);
        @(negedge clk);
        if (pend) compare("");
        io_addr = a[15:0]; io_valid = v; trap_en_a = ea; trap_en_b = eb;
        sel_serial = ss; sel_misc = sm; sel_audio = sa;
        exp_q = model(a, v, ea, eb, ss, sm, sa);
        pend = 1;
    endtask

    int bases[14] = '{'h1F0, 'h3F6, 'h170, 'h376, 'h3F0, 'h370, 'h300, 'h330,
                      'h60, 'h388, 'h530, 'h604, 'hE80, 'hF40};

    initial begin
        // R1: reset holds outputs low even with a hitting cycle present.
        io_addr = 16'h0060; io_valid = 1; trap_en_b = 8'hFF; trap_en_a = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        exp_q = '0;
        compare("R1");
        rst_n = 1;
        // R2: valid low gives no hit.
        step('h60, 0, 8'hFF, 8'hFF, 0, 0, 0);
        // R3: every serial code for A and B, at base and base+7 and base+8.
        for (int c = 0; c < 8; c++) begin
            step(ser_tab[c], 1, 8'h10, 0, 8'(c), 0, 0);
            step(ser_tab[c] + 7, 1, 8'h10, 0, 8'(c << 4), 0, 0);
            step(ser_tab[c] + 8, 1, 8'h10, 0, 8'(c), 0, 0);
        end
        // R4: parallel codes including unused code 3.
        for (int c = 0; c < 4; c++) begin
            step('h378, 1, 8'h10, 0, 8'h22, 8'(c), 0);
            step('h278, 1, 8'h10, 0, 8'h22, 8'(c), 0);
            step('h3BF, 1, 8'h10, 0, 8'h22, 8'(c), 0);
        end
        // R5: floppy select bit both ways.
        step('h3F2, 1, 8'h10, 0, 8'h22, 8'h10, 0);
        step('h372, 1, 8'h10, 0, 8'h22, 8'h00, 0);
        // R6: disk ranges and the single control byte.
        step('h3F6, 1, 8'h01, 0, 0, 0, 0);
        step('h3F7, 1, 8'h01, 0, 0, 0, 0);
        step('h177, 1, 8'h02, 0, 0, 0, 0);
        step('h376, 1, 8'h02, 0, 0, 0, 0);
        // R7 / R8 / R9: codec codes, MIDI bit, keyboard and FM edges.
        for (int c = 0; c < 4; c++) step(cod_tab[c] + 4, 1, 0, 8'h04, 0, 0, 8'(c << 4));
        step('h301, 1, 0, 8'h08, 0, 0, 8'h08);
        step('h331, 1, 0, 8'h08, 0, 0, 8'h00);
        step('h332, 1, 0, 8'h08, 0, 0, 8'h00);
        step('h63, 1, 0, 8'h10, 0, 0, 0);
        step('h64, 1, 0, 8'h10, 0, 0, 0);
        step('h38B, 1, 0, 8'h20, 0, 0, 0);
        // R10: overlaps (serial A=B, floppy over primary control byte).
        step('h3F8, 1, 8'h10, 0, 8'h00, 0, 0);
        step('h3F6, 1, 8'h11, 0, 8'h11, 8'h10, 0);
        // Random sweep around window edges (R2..R11).
        for (int i = 0; i < 4000; i++) begin
            int a;
            case ($urandom_range(0, 3))
                0: a = ser_tab[$urandom_range(0, 7)] + $urandom_range(0, 9) - 1;
                1: a = par_tab[$urandom_range(0, 2)] + $urandom_range(0, 9) - 1;
                2: a = $urandom_range(0, 65535);
                default: a = bases[$urandom_range(0, 13)] + $urandom_range(0, 9) - 1;
            endcase
            step(a & 'hFFFF, ($urandom_range(0, 7) != 0), 8'($urandom), 8'($urandom),
                 8'($urandom), 8'($urandom), 8'($urandom));
        end
        @(negedge clk);
        compare("");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule